// File: doc/BRIEF.md
# Indirect Parameter RAM Access Port

This block gives a bus master indirect access to a parameter memory through two 32-bit registers. The first is a control word. It sets an internal word pointer and chooses whether the port reads or writes. The second is a data window. Each access to it moves one memory word to or from the pointer location. When the pointer is told to step, successive data accesses walk through consecutive addresses. A whole table, such as one channel's filter coefficients at an offset of channel times 62 words, can therefore be loaded or dumped with one control write followed by a burst of data accesses.

The memory word width and depth are parameters. One configuration holds full 32-bit coefficients. A second holds 5-bit shift amounts. Narrow words are taken from the low bits of a write and read back zero-extended. Every data access finishes in a single clock with no busy flag, so a master may issue one access per cycle. The read pipeline fetches the word at the pointer ahead of time, so the first data read after a control write already returns the start word. Data reads change the pointer, so a master must never issue them speculatively.

Top module: `pram_port`

## Requirements
- R1: After reset the control register reads back 0x00004000 (stepping on, read direction, start address 0). The pointer is 0 and no read response is pending.
- R2: A control write with bit 13 set loads the pointer from bits 11:0. If that value is not below the memory depth, the pointer loads 0 instead. A control write with bit 13 clear keeps the current pointer.
- R3: When bit 12 of the control register is 1 (write direction), each data-register write stores the low DATA_W bits at the pointer. Back-to-back writes on consecutive cycles fill consecutive words.
- R4: When bit 12 is 0 (read direction), the first data read after a control write returns the word at the pointer. Further reads return consecutive words, one per cycle, with no gap.
- R5: When bit 14 of the control register is 0, data accesses leave the pointer unchanged, so repeated accesses all hit one word. When bit 14 is 1, each valid data access advances the pointer by one.
- R6: An access against the selected direction is ignored. A data write in read direction leaves the memory and the pointer unchanged. A data read in write direction returns 0 and leaves the pointer unchanged.
- R7: Advancing from address DEPTH-1 moves the pointer to address 0.
- R8: A read (bus_rd high, bus_wr low) gives bus_rvalid high with bus_rdata on the following cycle. A read with bus_sel 0 returns the stored control bits 14:0 with all upper bits zero.
- R9: With DATA_W below 32, written data is truncated to its low DATA_W bits and data reads return the word zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe; takes priority over bus_rd |
| bus_rd | input | 1 | Register read strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read response flag |

## Verification
The port is exercised with several patterns. A full-memory fill through one control write shows that the pointer walks every address and returns to zero. A burst that starts near the top of memory separates a correct wrap from a pointer that runs off the end. A read burst at a channel-sized offset shows whether the prefetch hands out the start word or its neighbour. Sequences with stepping disabled, with wrong-direction accesses and with a control write that leaves bit 13 clear are each followed by a stepping read burst. These tell a pointer that holds apart from one that moves. A second, 5-bit-wide instance shows truncation and zero extension.

// File: rtl/pram_pkg.sv
package pram_pkg;
    localparam int BUS_W   = 32;
    localparam int AF_W    = 12;
    localparam logic [BUS_W-1:0] CTRL_RST = 32'h0000_4000;

    typedef enum logic { DIR_READ = 1'b0, DIR_WRITE = 1'b1 } dir_e;
    typedef enum logic { SEL_CTRL = 1'b0, SEL_DATA = 1'b1 } sel_e;

    // bit 14 step, bit 13 load pointer, bit 12 direction, bits 11:0 start
    typedef struct packed {
        logic            step_en;
        logic            load_en;
        dir_e            dir;
        logic [AF_W-1:0] start;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
        return ctrl_t'(w);
    endfunction

    function automatic logic [BUS_W-1:0] pack_ctrl(input ctrl_t c);
        return {{(BUS_W-CTRL_W){1'b0}}, c};
    endfunction
endpackage

// File: rtl/pram_ctrl_reg.sv
module pram_ctrl_reg
    import pram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              load,
    output logic [AF_W-1:0]   load_addr
);
    ctrl_t ctrl_new;

    always_comb begin
        ctrl_new  = unpack_ctrl(wdata);
        load      = wr_en && ctrl_new.load_en;
        load_addr = ctrl_new.start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= unpack_ctrl(CTRL_RST[CTRL_W-1:0]);
        end else if (wr_en) begin
            ctrl_q <= ctrl_new;
        end
    end

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/pram_pointer.sv
module pram_pointer
    import pram_pkg::*;
#(
    parameter int DEPTH = 496,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [AF_W-1:0]  load_addr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr_q,
    output logic [PTR_W-1:0] ptr_nxt
);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    logic in_range;

    always_comb begin
        in_range = int'(load_addr) < DEPTH;
        ptr_nxt  = ptr_q;
        if (load) begin
            ptr_nxt = in_range ? load_addr[PTR_W-1:0] : '0;
        end else if (step) begin
            ptr_nxt = (ptr_q == LAST_P) ? '0 : ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_nxt;
    end

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && ptr_q == LAST_P) |=> ptr_q == '0);

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (load && in_range) |=> ptr_q == $past(load_addr[PTR_W-1:0]));

    // R2
    range_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !in_range) |=> ptr_q == '0);
endmodule

// File: rtl/pram_store.sv
module pram_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 496,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/pram_port.sv
module pram_port
    import pram_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 496
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic        bus_sel,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

    if (DEPTH < 2 || DEPTH > (1 << AF_W) || DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_cfg
        $error("pram_port: unsupported DEPTH or DATA_W");
    end

    ctrl_t             ctrl_q;
    logic              load;
    logic [AF_W-1:0]   load_addr;
    logic              step;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_nxt;
    logic [DATA_W-1:0] mem_q;
    logic              wr_ctrl, wr_data, rd_go, rd_data;
    logic              data_wr_ok, data_rd_ok;

    always_comb begin
        wr_ctrl    = bus_wr && (sel_e'(bus_sel) == SEL_CTRL);
        wr_data    = bus_wr && (sel_e'(bus_sel) == SEL_DATA);
        rd_go      = bus_rd && !bus_wr;
        rd_data    = rd_go && (sel_e'(bus_sel) == SEL_DATA);
        data_wr_ok = wr_data && (ctrl_q.dir == DIR_WRITE);
        data_rd_ok = rd_data && (ctrl_q.dir == DIR_READ);
        step       = (data_wr_ok || data_rd_ok) && ctrl_q.step_en;
    end

    pram_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ctrl),
        .wdata     (bus_wdata[CTRL_W-1:0]),
        .ctrl_q    (ctrl_q),
        .load      (load),
        .load_addr (load_addr)
    );

    pram_pointer #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (load_addr),
        .step      (step),
        .ptr_q     (ptr_q),
        .ptr_nxt   (ptr_nxt)
    );

    // Reading at the next pointer keeps mem_q equal to the word at ptr_q
    pram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk   (clk),
        .we    (data_wr_ok),
        .waddr (ptr_q),
        .wdata (bus_wdata[DATA_W-1:0]),
        .raddr (ptr_nxt),
        .rdata (mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd_go;
            if (rd_go) begin
                if (!rd_data)        bus_rdata <= pack_ctrl(ctrl_q);
                else if (data_rd_ok) bus_rdata <= BUS_W'(mem_q);
                else                 bus_rdata <= '0;
            end
        end
    end

    // R1
    reset_chk: assert property (@(posedge clk)
        rst |=> (!bus_rvalid && ptr_q == '0));

    // R8
    rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> bus_rvalid);

    // R8
    no_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> !bus_rvalid);

    // R6
    wrong_dir_chk: assert property (@(posedge clk) disable iff (rst)
        ((wr_data && !data_wr_ok) || (rd_data && !data_rd_ok)) |=> $stable(ptr_q));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((data_wr_ok || data_rd_ok) && !ctrl_q.step_en) |=> $stable(ptr_q));

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && ptr_q != LAST_P) |=> ptr_q == $past(ptr_q) + PTR_W'(1));
endmodule

// File: tb/pram_port_bench.sv
module pram_port_bench;
    localparam int DEPTH  = 496;
    localparam int NDEPTH = 112;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    logic        n_wr = 1'b0, n_rd = 1'b0, n_sel = 1'b0;
    logic [31:0] n_wdata = '0;
    logic [31:0] n_rdata;
    logic        n_rvalid;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_mem [DEPTH];
    int          m_ptr  = 0;
    logic [31:0] m_ctrl = 32'h0000_4000;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    pram_port u_pram_port (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    pram_port #(.DATA_W(5), .DEPTH(NDEPTH)) u_narrow (
        .clk(clk), .rst(rst), .bus_wr(n_wr), .bus_rd(n_rd), .bus_sel(n_sel),
        .bus_wdata(n_wdata), .bus_rdata(n_rdata), .bus_rvalid(n_rvalid)
    );

    function automatic void m_step();
        if (m_ctrl[14]) m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
    endfunction

    task automatic idle();
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic ctrl_wr(input logic [31:0] v);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_sel = 1'b0; bus_wdata = v;
        m_ctrl = v & 32'h0000_7FFF;
        if (v[13]) m_ptr = (int'(v[11:0]) < DEPTH) ? int'(v[11:0]) : 0;
        @(negedge clk); idle();
    endtask

    task automatic data_wr(input logic [31:0] v);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_sel = 1'b1; bus_wdata = v;
        if (m_ctrl[12]) begin
            m_mem[m_ptr] = v;
            m_step();
        end
        @(negedge clk); idle();
    endtask

    task automatic reg_rd(input logic sel, input string tag);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_sel = sel;
        if (!sel) begin
            exp_q.push_back(m_ctrl);
        end else if (m_ctrl[12]) begin
            exp_q.push_back(32'h0);
        end else begin
            exp_q.push_back(m_mem[m_ptr]);
            m_step();
        end
        tag_q.push_back(tag);
        @(negedge clk); idle();
    endtask

    // monitor: pops one expectation per response
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected response actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic n_access(input logic wr, input logic sel, input logic [31:0] v);
        n_wr = wr; n_rd = !wr; n_sel = sel; n_wdata = v;
        @(negedge clk);
        n_wr = 1'b0; n_rd = 1'b0;
    endtask

    task automatic n_check(input logic [31:0] e);
        n_access(1'b0, 1'b1, 32'h0);
        checks++;
        if (n_rvalid !== 1'b1 || n_rdata !== e) begin
            errors++;
            $display("FAIL R9 narrow read actual %h expected %h", n_rdata, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset value of control
        reg_rd(1'b0, "R1 control reset value");
        // R3 R7: fill the whole memory; pointer wraps back to 0
        ctrl_wr(32'h0000_7000);
        for (int i = 0; i < DEPTH; i++) data_wr(32'hA500_0000 ^ (i * 32'h0001_0203));
        data_wr(32'h1234_5678);                          // lands at 0 after wrap (R7)
        ctrl_wr(32'h0000_6000);
        reg_rd(1'b1, "R7 word 0 after wrap");
        reg_rd(1'b1, "R3 word 1 after fill");
        // R4: channel region at 3*62, back-to-back reads
        ctrl_wr(32'h0000_7000 | 32'(3 * 62));
        for (int i = 0; i < 62; i++) data_wr(32'hC0DE_0000 + 32'(i));
        ctrl_wr(32'h0000_6000 | 32'(3 * 62));
        for (int i = 0; i < 62; i++) reg_rd(1'b1, "R4 channel burst");
        // R8: control readback
        reg_rd(1'b0, "R8 control readback");
        // R7: wrap on write and read bursts
        ctrl_wr(32'h0000_7000 | 32'(DEPTH - 2));
        for (int i = 0; i < 5; i++) data_wr(32'h7700_0000 + 32'(i));
        ctrl_wr(32'h0000_6000 | 32'(DEPTH - 2));
        for (int i = 0; i < 4; i++) reg_rd(1'b1, "R7 wrap burst");
        // R2: no-load control write keeps the pointer (now at 2)
        ctrl_wr(32'h0000_4000 | 32'd77);
        reg_rd(1'b1, "R2 pointer kept");
        // R2: out-of-range start loads 0
        ctrl_wr(32'h0000_6FFF);
        reg_rd(1'b1, "R2 out of range start");
        // R5: stepping off
        ctrl_wr(32'h0000_3000 | 32'd20);
        data_wr(32'hAAAA_0001);
        data_wr(32'hBBBB_0002);
        ctrl_wr(32'h0000_2000 | 32'd20);
        for (int i = 0; i < 3; i++) reg_rd(1'b1, "R5 hold read");
        ctrl_wr(32'h0000_6000 | 32'd20);
        reg_rd(1'b1, "R5 held word");
        reg_rd(1'b1, "R5 neighbour untouched");
        // R6: write in read direction ignored
        ctrl_wr(32'h0000_6000 | 32'd30);
        data_wr(32'hDEAD_BEEF);
        reg_rd(1'b1, "R6 write ignored");
        reg_rd(1'b1, "R6 pointer kept after ignored write");
        // R6: read in write direction returns 0, no advance
        ctrl_wr(32'h0000_7000 | 32'd40);
        reg_rd(1'b1, "R6 read in write mode");
        data_wr(32'h0F0F_4040);
        ctrl_wr(32'h0000_6000 | 32'd40);
        reg_rd(1'b1, "R6 write after ignored read");
        reg_rd(1'b1, "R6 next word");
        // R9: narrow instance
        n_access(1'b1, 1'b0, 32'h0000_7000 | 32'd13);
        n_access(1'b1, 1'b1, 32'hFFFF_FFF3);
        n_access(1'b1, 1'b1, 32'h0000_002A);
        n_access(1'b1, 1'b0, 32'h0000_6000 | 32'd13);
        n_check(32'h0000_0013);
        n_check(32'h0000_000A);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 missing responses actual %0d expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule